// File: doc/BRIEF.md
# USB Controller Reset and Clock Bring-Up Sequencer

This block drives the reset, clock-divider and power control bits of a USB controller wrapper from one start command. It first works out a divider select code from the system clock rate, so that the controller clock runs at 300 MHz or less. It then walks the control outputs through a fixed release order, with a minimum dwell at each stage. In the middle of the order it asks an external agent to check the PHY PLL and waits for the answer. A good answer finishes the order. A bad answer leaves the wrapper parked in reset and raises `fail`.

The system clock rate arrives in MHz on `sys_rate_mhz`. An iterative ceiling divider turns it into a raw division ratio, and a threshold ladder maps that ratio onto a 3-bit select code. All dwell times are parameters counted in system clock cycles. The power-up dwell is scaled by the actual division factor, so that it always covers `CTRL_CLKS` controller clocks. A 4-bit `step` output exposes the current stage.

States and transitions:
- IDLE(0) goes to RST_ALL on `start`.
- RST_ALL(1) goes to CALC.
- CALC(2) goes to DIV_RST once the divider finishes.
- DIV_RST(3) goes to DIV_LOAD, which goes to DIV_RUN, which goes to PWR_UP.
- PWR_UP(6) goes to WRAP_REL when its timer expires.
- WRAP_REL(7) goes to HC_REL when its timer expires.
- HC_REL(8) goes to SOFT_RST.
- SOFT_RST(9) goes to PHY_REL when its timer expires.
- PHY_REL(10) goes to PLL_REQ when its timer expires.
- PLL_REQ(11) goes to PLL_WAIT.
- PLL_WAIT(12) goes to SOFT_REL on `pll_done` with `pll_ok` high, and to FAIL on `pll_done` with `pll_ok` low.
- SOFT_REL(13) goes to DONE.
- DONE(14) and FAIL(15) go to RST_ALL on `start`.

Top module: `usb_bringup_seq`

## Requirements
- R1: The raw ratio q is ceil(rate/DIVISOR), with rate in MHz and DIVISOR defaulting to 300. CALC lasts q+2 cycles. The select code is 0 for q≤1, 1 for q≤2, 2 for q≤4, 3 for q≤6, 4 for q≤8, 5 for q≤16, 6 for q≤24, and 7 otherwise. `div_sel` takes the code on entry to DIV_LOAD and holds it until the next DIV_LOAD.
- R2: After reset, `step` is 0, every control output is 0, and `div_sel` is 0.
- R3: `start` is acted on only in IDLE, DONE or FAIL. In any other state it has no effect on the sequence.
- R4: RST_ALL and CALC assert `phy_rst`, `hc_rst` and `wrap_rst`. DIV_RST adds `div_rst`. DIV_LOAD adds `clk_en`. DIV_RUN drops `div_rst`. Each of RST_ALL, DIV_RST, DIV_LOAD and DIV_RUN lasts exactly one cycle.
- R5: PWR_UP raises `hs_pwr_en` and `ss_pwr_en` and lasts CTRL_CLKS×F cycles. F is 1 for code 0, 2×code for codes 1 to 4, and 8×(code−3) for codes 5 to 7.
- R6: WRAP_REL drops `wrap_rst` and lasts HC_WAIT cycles. HC_REL then drops `hc_rst` for one cycle.
- R7: SOFT_RST asserts `phy_soft_rst` and `core_soft_rst`, sets `port_dir` to 1 (host), and lasts PHY_WAIT cycles. PHY_REL then drops `phy_rst` and lasts PLL_SETTLE cycles.
- R8: PLL_REQ drives `pll_req` high for exactly one cycle. PLL_WAIT holds until `pll_done`. `pll_done` is ignored in every other state.
- R9: When `pll_ok` is high with `pll_done`, SOFT_REL drops both soft resets for one cycle. DONE then holds the same outputs with `done` high.
- R10: When `pll_ok` is low with `pll_done`, FAIL raises `fail` and re-asserts all three resets. It clears both power enables, keeps the soft resets asserted, and keeps `clk_en` and `port_dir` unchanged.
- R11: `step` carries the state number listed above, and `done` and `fail` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a bring-up sequence |
| sys_rate_mhz | input | RATE_W | System clock rate in MHz |
| pll_done | input | 1 | PLL check result is valid |
| pll_ok | input | 1 | PLL check passed (valid with pll_done) |
| phy_rst | output | 1 | PHY reset |
| hc_rst | output | 1 | Host-controller reset |
| wrap_rst | output | 1 | Wrapper reset |
| div_rst | output | 1 | Controller clock divider reset |
| div_sel | output | 3 | Divider select code |
| clk_en | output | 1 | Controller clock enable |
| hs_pwr_en | output | 1 | High-speed PHY power enable |
| ss_pwr_en | output | 1 | SuperSpeed PHY power enable |
| phy_soft_rst | output | 1 | PHY soft reset |
| core_soft_rst | output | 1 | Core soft reset |
| port_dir | output | 2 | Port direction (1 = host) |
| pll_req | output | 1 | One-cycle PLL check request |
| step | output | 4 | Current state number |
| done | output | 1 | Sequence completed |
| fail | output | 1 | Sequence aborted on a PLL failure |

## Verification
Every output is decoded from the registered state, so each stage becomes visible one clock edge after the cycle in which its entry condition was present. A `start` sampled at an edge shows as step 1 in the next cycle. CALC's length follows from the ceiling ratio, each timed stage lasts exactly its parameter, and a `pll_done` presented in the k-th PLL_WAIT cycle moves the sequence on at the following edge. The bench builds the expected step of every cycle from these dwell rules and compares all outputs at each falling edge. It also responds to `pll_req` after a chosen number of cycles, and injects a stray `start` and a stray failing `pll_done` mid-sequence to show that both are ignored.

// File: rtl/bringup_pkg.sv
package bringup_pkg;

    typedef enum logic [3:0] {
        ST_IDLE     = 4'd0,
        ST_RST_ALL  = 4'd1,
        ST_CALC     = 4'd2,
        ST_DIV_RST  = 4'd3,
        ST_DIV_LOAD = 4'd4,
        ST_DIV_RUN  = 4'd5,
        ST_PWR_UP   = 4'd6,
        ST_WRAP_REL = 4'd7,
        ST_HC_REL   = 4'd8,
        ST_SOFT_RST = 4'd9,
        ST_PHY_REL  = 4'd10,
        ST_PLL_REQ  = 4'd11,
        ST_PLL_WAIT = 4'd12,
        ST_SOFT_REL = 4'd13,
        ST_DONE     = 4'd14,
        ST_FAIL     = 4'd15
    } seq_state_e;

    typedef struct packed {
        logic       phy_rst;
        logic       hc_rst;
        logic       wrap_rst;
        logic       div_rst;
        logic       clk_en;
        logic       hs_pwr;
        logic       ss_pwr;
        logic       phy_soft;
        logic       core_soft;
        logic [1:0] dir;
        logic       pll_req;
        logic       done;
        logic       fail;
    } ctrl_t;

    localparam logic [1:0] DIR_HOST = 2'd1;

    // Division factor for a select code; code 0 passes the clock through.
    function automatic logic [5:0] div_factor(input logic [2:0] code);
        logic [5:0] f;
        if (code == 3'd0)
            f = 6'd1;
        else if (code < 3'd5)
            f = {2'b00, code, 1'b0};
        else
            f = {code - 3'd3, 3'b000};
        return f;
    endfunction

endpackage

// File: rtl/ceil_divider.sv
module ceil_divider #(
    parameter int RATE_W  = 16,
    parameter int DIVISOR = 300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [RATE_W-1:0] rate,
    output logic              busy,
    output logic [RATE_W-1:0] quot
);
    localparam logic [RATE_W:0] STEP_V = (RATE_W+1)'(DIVISOR);

    logic [RATE_W:0] acc_q;

    // Adds DIVISOR until the sum covers the rate; the count is the ceiling.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            acc_q <= '0;
            quot  <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            acc_q <= '0;
            quot  <= '0;
        end else if (busy) begin
            if (acc_q >= {1'b0, rate}) begin
                busy <= 1'b0;
            end else begin
                acc_q <= acc_q + STEP_V;
                quot  <= quot + RATE_W'(1);
            end
        end
    end

endmodule

// File: rtl/rate_to_code.sv
module rate_to_code #(
    parameter int Q_W = 16
) (
    input  logic [Q_W-1:0] quot,
    output logic [2:0]     code
);
    localparam int NUM_TH = 7;
    localparam int TH [NUM_TH] = '{1, 2, 4, 6, 8, 16, 24};

    // Smallest threshold that still covers the ratio wins.
    always_comb begin
        code = 3'd7;
        for (int i = NUM_TH - 1; i >= 0; i--) begin
            if (quot <= Q_W'(TH[i]))
                code = 3'(i);
        end
    end

endmodule

// File: rtl/dwell_timer.sv
module dwell_timer #(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/usb_bringup_seq.sv
module usb_bringup_seq
    import bringup_pkg::*;
#(
    parameter int RATE_W     = 16,
    parameter int DIVISOR    = 300,
    parameter int CTRL_CLKS  = 10,
    parameter int HC_WAIT    = 20,
    parameter int PHY_WAIT   = 1000,
    parameter int PLL_SETTLE = 4500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [RATE_W-1:0] sys_rate_mhz,
    input  logic              pll_done,
    input  logic              pll_ok,
    output logic              phy_rst,
    output logic              hc_rst,
    output logic              wrap_rst,
    output logic              div_rst,
    output logic [2:0]        div_sel,
    output logic              clk_en,
    output logic              hs_pwr_en,
    output logic              ss_pwr_en,
    output logic              phy_soft_rst,
    output logic              core_soft_rst,
    output logic [1:0]        port_dir,
    output logic              pll_req,
    output logic [3:0]        step,
    output logic              done,
    output logic              fail
);
    localparam int MAX_FACTOR = 32;
    localparam int PWR_MAX    = CTRL_CLKS * MAX_FACTOR;
    localparam int M1         = (PWR_MAX > HC_WAIT) ? PWR_MAX : HC_WAIT;
    localparam int M2         = (M1 > PHY_WAIT) ? M1 : PHY_WAIT;
    localparam int MAX_DWELL  = (M2 > PLL_SETTLE) ? M2 : PLL_SETTLE;
    localparam int CNT_W      = $clog2(MAX_DWELL + 1);

    seq_state_e        state_q, state_d;
    logic              div_busy;
    logic [RATE_W-1:0] ratio;
    logic [2:0]        code;
    logic [2:0]        div_sel_q;
    logic              tmr_zero;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    int                pwr_cycles;
    ctrl_t             ctl;

    ceil_divider #(.RATE_W(RATE_W), .DIVISOR(DIVISOR)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (state_q == ST_RST_ALL),
        .rate  (sys_rate_mhz),
        .busy  (div_busy),
        .quot  (ratio)
    );

    rate_to_code #(.Q_W(RATE_W)) u_code (
        .quot (ratio),
        .code (code)
    );

    dwell_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Select code register, loaded as the sequence enters DIV_LOAD.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_sel_q <= '0;
        else if (state_q == ST_DIV_RST)
            div_sel_q <= code;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE, ST_FAIL: if (start) state_d = ST_RST_ALL;
            ST_RST_ALL:  state_d = ST_CALC;
            ST_CALC:     if (!div_busy) state_d = ST_DIV_RST;
            ST_DIV_RST:  state_d = ST_DIV_LOAD;
            ST_DIV_LOAD: state_d = ST_DIV_RUN;
            ST_DIV_RUN:  state_d = ST_PWR_UP;
            ST_PWR_UP:   if (tmr_zero) state_d = ST_WRAP_REL;
            ST_WRAP_REL: if (tmr_zero) state_d = ST_HC_REL;
            ST_HC_REL:   state_d = ST_SOFT_RST;
            ST_SOFT_RST: if (tmr_zero) state_d = ST_PHY_REL;
            ST_PHY_REL:  if (tmr_zero) state_d = ST_PLL_REQ;
            ST_PLL_REQ:  state_d = ST_PLL_WAIT;
            ST_PLL_WAIT: if (pll_done) state_d = pll_ok ? ST_SOFT_REL : ST_FAIL;
            ST_SOFT_REL: state_d = ST_DONE;
        endcase
    end

    // Dwell load: a timed state occupies exactly its dwell in cycles.
    assign pwr_cycles = CTRL_CLKS * int'(div_factor(div_sel_q));
    assign tmr_load   = (state_d != state_q);

    always_comb begin
        case (state_d)
            ST_PWR_UP:   tmr_val = CNT_W'(pwr_cycles - 1);
            ST_WRAP_REL: tmr_val = CNT_W'(HC_WAIT - 1);
            ST_SOFT_RST: tmr_val = CNT_W'(PHY_WAIT - 1);
            ST_PHY_REL:  tmr_val = CNT_W'(PLL_SETTLE - 1);
            default:     tmr_val = '0;
        endcase
    end

    // Output decode, Moore style.
    always_comb begin
        ctl = '0;
        case (state_q)
            ST_RST_ALL, ST_CALC: begin
                ctl.phy_rst = 1'b1; ctl.hc_rst = 1'b1; ctl.wrap_rst = 1'b1;
            end
            ST_DIV_RST: begin
                ctl.phy_rst = 1'b1; ctl.hc_rst = 1'b1; ctl.wrap_rst = 1'b1;
                ctl.div_rst = 1'b1;
            end
            ST_DIV_LOAD: begin
                ctl.phy_rst = 1'b1; ctl.hc_rst = 1'b1; ctl.wrap_rst = 1'b1;
                ctl.div_rst = 1'b1; ctl.clk_en = 1'b1;
            end
            ST_DIV_RUN: begin
                ctl.phy_rst = 1'b1; ctl.hc_rst = 1'b1; ctl.wrap_rst = 1'b1;
                ctl.clk_en  = 1'b1;
            end
            ST_PWR_UP: begin
                ctl.phy_rst = 1'b1; ctl.hc_rst = 1'b1; ctl.wrap_rst = 1'b1;
                ctl.clk_en  = 1'b1; ctl.hs_pwr = 1'b1; ctl.ss_pwr = 1'b1;
            end
            ST_WRAP_REL: begin
                ctl.phy_rst = 1'b1; ctl.hc_rst = 1'b1;
                ctl.clk_en  = 1'b1; ctl.hs_pwr = 1'b1; ctl.ss_pwr = 1'b1;
            end
            ST_HC_REL: begin
                ctl.phy_rst = 1'b1;
                ctl.clk_en  = 1'b1; ctl.hs_pwr = 1'b1; ctl.ss_pwr = 1'b1;
            end
            ST_SOFT_RST: begin
                ctl.phy_rst  = 1'b1;
                ctl.clk_en   = 1'b1; ctl.hs_pwr = 1'b1; ctl.ss_pwr = 1'b1;
                ctl.phy_soft = 1'b1; ctl.core_soft = 1'b1; ctl.dir = DIR_HOST;
            end
            ST_PHY_REL, ST_PLL_WAIT: begin
                ctl.clk_en   = 1'b1; ctl.hs_pwr = 1'b1; ctl.ss_pwr = 1'b1;
                ctl.phy_soft = 1'b1; ctl.core_soft = 1'b1; ctl.dir = DIR_HOST;
            end
            ST_PLL_REQ: begin
                ctl.clk_en   = 1'b1; ctl.hs_pwr = 1'b1; ctl.ss_pwr = 1'b1;
                ctl.phy_soft = 1'b1; ctl.core_soft = 1'b1; ctl.dir = DIR_HOST;
                ctl.pll_req  = 1'b1;
            end
            ST_SOFT_REL: begin
                ctl.clk_en = 1'b1; ctl.hs_pwr = 1'b1; ctl.ss_pwr = 1'b1;
                ctl.dir    = DIR_HOST;
            end
            ST_DONE: begin
                ctl.clk_en = 1'b1; ctl.hs_pwr = 1'b1; ctl.ss_pwr = 1'b1;
                ctl.dir    = DIR_HOST; ctl.done = 1'b1;
            end
            ST_FAIL: begin
                ctl.phy_rst  = 1'b1; ctl.hc_rst = 1'b1; ctl.wrap_rst = 1'b1;
                ctl.clk_en   = 1'b1;
                ctl.phy_soft = 1'b1; ctl.core_soft = 1'b1; ctl.dir = DIR_HOST;
                ctl.fail     = 1'b1;
            end
            default: ctl = '0;
        endcase
    end

    assign phy_rst       = ctl.phy_rst;
    assign hc_rst        = ctl.hc_rst;
    assign wrap_rst      = ctl.wrap_rst;
    assign div_rst       = ctl.div_rst;
    assign clk_en        = ctl.clk_en;
    assign hs_pwr_en     = ctl.hs_pwr;
    assign ss_pwr_en     = ctl.ss_pwr;
    assign phy_soft_rst  = ctl.phy_soft;
    assign core_soft_rst = ctl.core_soft;
    assign port_dir      = ctl.dir;
    assign pll_req       = ctl.pll_req;
    assign done          = ctl.done;
    assign fail          = ctl.fail;
    assign div_sel       = div_sel_q;
    assign step          = state_q;

endmodule

// File: rtl/usb_bringup_chk.sv
module usb_bringup_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       phy_rst,
    input logic       hc_rst,
    input logic       wrap_rst,
    input logic       div_rst,
    input logic [2:0] div_sel,
    input logic       clk_en,
    input logic       hs_pwr_en,
    input logic       ss_pwr_en,
    input logic       phy_soft_rst,
    input logic       core_soft_rst,
    input logic [1:0] port_dir,
    input logic       pll_req,
    input logic       done,
    input logic       fail
);
    AST_HC_AFTER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !hc_rst |-> !wrap_rst); // R6

    AST_PHY_AFTER_HC: assert property (@(posedge clk) disable iff (!rst_n)
        !phy_rst |-> !hc_rst); // R7

    AST_WRAP_REL_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wrap_rst) |-> (hs_pwr_en && ss_pwr_en && clk_en)); // R5

    AST_PHY_REL_SOFT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phy_rst) |-> (core_soft_rst && phy_soft_rst && port_dir == 2'd1)); // R7

    AST_PLL_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pll_req |=> !pll_req); // R8

    AST_DONE_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (!core_soft_rst && !phy_soft_rst && !phy_rst)); // R9

    AST_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !div_rst) |-> $stable(div_sel)); // R1

    AST_DONE_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail)); // R11

endmodule

bind usb_bringup_seq usb_bringup_chk u_chk (.*);

// File: tb/usb_bringup_seq_tb.sv
module usb_bringup_seq_tb;
    localparam int CTRL_CLKS  = 10;
    localparam int HC_WAIT    = 20;
    localparam int PHY_WAIT   = 1000;
    localparam int PLL_SETTLE = 4500;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] sys_rate_mhz = '0;
    logic        pll_done = 1'b0;
    logic        pll_ok = 1'b0;
    logic        phy_rst, hc_rst, wrap_rst, div_rst, clk_en;
    logic        hs_pwr_en, ss_pwr_en, phy_soft_rst, core_soft_rst;
    logic [2:0]  div_sel;
    logic [1:0]  port_dir;
    logic        pll_req, done, fail;
    logic [3:0]  step;

    int tests = 0;
    int fails = 0;
    int exp_sel = 0;

    always #5 clk = ~clk;

    usb_bringup_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .sys_rate_mhz(sys_rate_mhz),
        .pll_done(pll_done), .pll_ok(pll_ok), .phy_rst(phy_rst), .hc_rst(hc_rst),
        .wrap_rst(wrap_rst), .div_rst(div_rst), .div_sel(div_sel), .clk_en(clk_en),
        .hs_pwr_en(hs_pwr_en), .ss_pwr_en(ss_pwr_en), .phy_soft_rst(phy_soft_rst),
        .core_soft_rst(core_soft_rst), .port_dir(port_dir), .pll_req(pll_req),
        .step(step), .done(done), .fail(fail)
    );

    // Expected {phy,hc,wrap,divrst,clken,hs,ss,psoft,csoft,dir[1:0],req,done,fail}.
    function automatic logic [13:0] exp_bits(input int s);
        case (s)
            1, 2:    return 14'b111_0000_00_00_000;
            3:       return 14'b111_1000_00_00_000;
            4:       return 14'b111_1100_00_00_000;
            5:       return 14'b111_0100_00_00_000;
            6:       return 14'b111_0111_00_00_000;
            7:       return 14'b110_0111_00_00_000;
            8:       return 14'b100_0111_00_00_000;
            9:       return 14'b100_0111_11_01_000;
            10, 12:  return 14'b000_0111_11_01_000;
            11:      return 14'b000_0111_11_01_100;
            13:      return 14'b000_0111_00_01_000;
            14:      return 14'b000_0111_00_01_010;
            15:      return 14'b111_0100_11_01_001;
            default: return 14'b0;
        endcase
    endfunction

    function automatic string req_of(input int s);
        case (s)
            1, 2, 3, 4, 5: return "R4";
            6:             return "R5";
            7, 8:          return "R6";
            9, 10:         return "R7";
            11, 12:        return "R8";
            13, 14:        return "R9";
            15:            return "R10";
            default:       return "R2";
        endcase
    endfunction

    function automatic int code_of(input int q);
        if (q <= 1) return 0;
        if (q <= 2) return 1;
        if (q <= 4) return 2;
        if (q <= 6) return 3;
        if (q <= 8) return 4;
        if (q <= 16) return 5;
        if (q <= 24) return 6;
        return 7;
    endfunction

    function automatic int factor_of(input int c);
        if (c == 0) return 1;
        if (c < 5) return 2 * c;
        return 8 * (c - 3);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h (time %0t)", req, act, exp, $time);
        end
    endtask

    task automatic compare(input int e);
        logic [13:0] act;
        act = {phy_rst, hc_rst, wrap_rst, div_rst, clk_en, hs_pwr_en, ss_pwr_en,
               phy_soft_rst, core_soft_rst, port_dir, pll_req, done, fail};
        check("R11 step", int'(step), e);
        check({req_of(e), " outputs"}, int'(act), int'(exp_bits(e)));
        check("R1 div_sel", int'(div_sel), exp_sel);
    endtask

    // Runs one sequence; k is the PLL_WAIT cycle in which pll_done is given.
    // inject drives a stray start (R3) and a stray failing pll_done (R8).
    task automatic run_seq(input int rate, input bit ok, input int k, input bit inject);
        int q, code, f, wcnt, e;
        int expq[$];
        bit inj_s, inj_p;
        q = (rate + 299) / 300;
        code = code_of(q);
        f = factor_of(code);
        expq.push_back(1);
        repeat (q + 2) expq.push_back(2);
        expq.push_back(3); expq.push_back(4); expq.push_back(5);
        repeat (CTRL_CLKS * f) expq.push_back(6);
        repeat (HC_WAIT) expq.push_back(7);
        expq.push_back(8);
        repeat (PHY_WAIT) expq.push_back(9);
        repeat (PLL_SETTLE) expq.push_back(10);
        expq.push_back(11);
        repeat (k) expq.push_back(12);
        if (ok) begin
            expq.push_back(13);
            repeat (3) expq.push_back(14);
        end else begin
            repeat (3) expq.push_back(15);
        end
        wcnt = 0; inj_s = 0; inj_p = 0;
        @(negedge clk);
        sys_rate_mhz = 16'(rate);
        start = 1'b1;
        while (expq.size() > 0) begin
            @(negedge clk);
            start = 1'b0; pll_done = 1'b0; pll_ok = 1'b0;
            e = expq.pop_front();
            if (e == 4) exp_sel = code;
            compare(e);
            if (e == 11) wcnt = 0;
            if (e == 12) begin
                wcnt++;
                if (wcnt == k) begin pll_done = 1'b1; pll_ok = ok; end
            end
            if (inject && e == 7 && !inj_s) begin start = 1'b1; inj_s = 1; end
            if (inject && e == 10 && !inj_p) begin pll_done = 1'b1; pll_ok = 1'b0; inj_p = 1; end
        end
    endtask

    initial begin
        #(150000 * 10);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2: reset state
        compare(0);
        rst_n = 1'b1;
        @(negedge clk);
        compare(0);
        run_seq(800, 1'b1, 3, 1'b1);   // q=3 code 2, R3 and R8 injections
        run_seq(0, 1'b0, 1, 1'b0);     // q=0 code 0, R10 abort
        run_seq(7200, 1'b1, 5, 1'b0);  // q=24 code 6, restart from FAIL (R3)
        run_seq(9000, 1'b1, 2, 1'b0);  // q=30 code 7
        run_seq(300, 1'b1, 1, 1'b0);   // q=1 code 0 boundary
        run_seq(301, 1'b1, 1, 1'b0);   // q=2 code 1 boundary
        run_seq(1800, 1'b1, 2, 1'b0);  // q=6 code 3
        run_seq(4800, 1'b0, 2, 1'b0);  // q=16 code 5, R10 abort
        run_seq(2000, 1'b1, 4, 1'b0);  // q=7 code 4
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule